// File: doc/BRIEF.md
# Edge-offset synchronous FIFO

This block is a single-clock first-in first-out buffer whose storage writes and storage reads never happen at the same clock instant. The producer drives a write enable and write data on the rising edge as usual. A small input stage captures them on that edge and commits them to the storage array and the write pointer on the following falling edge. Reads, the read pointer, the registered read data and the empty indications all stay on the rising edge. A write and a read issued together therefore update the storage half a period apart, and the read side gains no extra latency.

The block reports fill level through programmable thresholds. The almost-empty flag rises when few words remain, and empty is decoded from it. There is no full output, because the input stage would make it arrive too late to be useful. The producer instead stops on the almost-full flag, which rises when free space falls to a programmable margin. Two error pulses report a write that found no room and a read that found nothing to return. Neither rejected operation alters the buffer.

Top module: `edge_offset_fifo`

## Requirements
- R1: While `rst` is high and in the first sample after it falls, `empty` and `almost_empty` are 1. `almost_full`, `wr_err` and `rd_err` are 0, and `rd_data` is all zeros.
- R2: A write presented with `wr_en` before a rising edge is captured on that edge and committed to storage on the next falling edge. Its effect on the flags is visible before the following rising edge. Words are returned in the order they were written.
- R3: A read presented with `rd_en` while `empty` is 0 is accepted on the rising edge. The oldest word appears on `rd_data` just after that edge, and the flags reflect the removal from the same edge on, with no added cycles.
- R4: With `count` the number of stored words, `almost_empty` is 1 exactly when `count <= AE_OFS`. `empty` is 1 exactly when `almost_empty` is 1 and `count == 0`.
- R5: `almost_full` is 1 exactly when `DEPTH - count <= AF_OFS`. No full flag is provided.
- R6: A staged write that reaches the falling edge while `count == DEPTH` is dropped. `wr_err` is 1 for that cycle (from that falling edge to the next), and the stored words and their order are unchanged.
- R7: A read presented while `empty` is 1 is refused. `rd_err` is 1 for the following cycle, `rd_data` keeps its value, and the count is unchanged.
- R8: When `count` equals `AE_OFS`, having arrived there from above or from below, a simultaneous read and write leaves `count` unchanged and `almost_empty` stays 1.
- R9: In a cycle with both enables, the read is judged against the count before the write and the write against the count after the read. On an empty buffer the read is refused and the write accepted. On a full buffer both are accepted.
- R10: A producer that writes on every cycle and stops once it samples `almost_full` high never causes `wr_err`, provided `AF_OFS >= 1`. The count then settles at `DEPTH - AF_OFS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; reads on rising edge, storage writes on falling edge |
| rst | input | 1 | Active-high synchronous reset |
| wr_en | input | 1 | Write request, sampled on rising edge |
| wr_data | input | DATA_W | Write word, sampled with `wr_en` |
| rd_en | input | 1 | Read request, sampled on rising edge |
| rd_data | output | DATA_W | Registered read word |
| empty | output | 1 | No words stored |
| almost_empty | output | 1 | Count at or below `AE_OFS` |
| almost_full | output | 1 | Free space at or below `AF_OFS` |
| wr_err | output | 1 | Last committed write found no room |
| rd_err | output | 1 | Last read found the buffer empty |

## Verification
The bench builds the block with `DATA_W = 8`, `DEPTH = 8`, `AE_OFS = 2` and `AF_OFS = 2`. The shallow depth lets a few cycles of writes fill the storage, which brings the write-overflow error and the full-buffer simultaneous read and write within reach. The low almost-empty threshold lets the threshold case be entered both from above and from below in short sequences. The small almost-full margin puts the throttled producer's settling point two words below full, where any write arriving one cycle late would still fit.

// File: rtl/efifo_pkg.sv
package efifo_pkg;

    // Pointer width carrying one wrap bit beyond the address.
    function automatic int ptr_width(input int depth);
        return $clog2(depth) + 1;
    endfunction

    // Error pulse pair produced by the two control halves.
    typedef struct packed {
        logic wr_err;
        logic rd_err;
    } efifo_err_t;

endpackage

// File: rtl/efifo_wr_stage.sv
module efifo_wr_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              stg_vld,
    output logic [DATA_W-1:0] stg_data
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t stage_d, stage_q;

    // Capture on the rising edge; commit happens half a period later.
    always_comb begin
        stage_d      = stage_q;
        stage_d.vld  = wr_en;
        if (wr_en) begin
            stage_d.data = wr_data;
        end
        if (rst) begin
            stage_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

    assign stg_vld  = stage_q.vld;
    assign stg_data = stage_q.data;

endmodule

// File: rtl/efifo_store.sv
module efifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage write port lives on the falling edge.
    always_ff @(negedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous look-up; the read controller registers the word.
    assign rdata = mem[raddr];

endmodule

// File: rtl/efifo_wr_ctrl.sv
module efifo_wr_ctrl #(
    parameter int DEPTH = 16,
    localparam int PW   = efifo_pkg::ptr_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stg_vld,
    input  logic [PW-1:0] rd_ptr,
    output logic          mem_we,
    output logic [PW-1:0] wr_ptr,
    output logic          wr_err
);

    localparam logic [PW-1:0] DEPTH_L = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          err;
    } wctl_t;

    wctl_t wctl_d, wctl_q;
    logic  no_room;

    // rd_ptr has settled since the previous rising edge, so the
    // room check already includes any read from the same cycle.
    always_comb begin
        no_room    = ((wctl_q.ptr - rd_ptr) == DEPTH_L);
        mem_we     = stg_vld && !no_room && !rst;
        wctl_d     = wctl_q;
        wctl_d.err = stg_vld && no_room;
        if (mem_we) begin
            wctl_d.ptr = wctl_q.ptr + PW'(1);
        end
        if (rst) begin
            wctl_d = '0;
        end
    end

    always_ff @(negedge clk) begin
        wctl_q <= wctl_d;
    end

    assign wr_ptr = wctl_q.ptr;
    assign wr_err = wctl_q.err;

endmodule

// File: rtl/efifo_rd_ctrl.sv
module efifo_rd_ctrl #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int PW    = efifo_pkg::ptr_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              is_empty,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PW-1:0]     rd_ptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);

    typedef struct packed {
        logic [PW-1:0]     ptr;
        logic [DATA_W-1:0] data;
        logic              err;
    } rctl_t;

    rctl_t rctl_d, rctl_q;
    logic  take;

    always_comb begin
        take       = rd_en && !is_empty;
        rctl_d     = rctl_q;
        rctl_d.err = rd_en && is_empty;
        if (take) begin
            rctl_d.data = mem_rdata;
            rctl_d.ptr  = rctl_q.ptr + PW'(1);
        end
        if (rst) begin
            rctl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        rctl_q <= rctl_d;
    end

    assign rd_ptr  = rctl_q.ptr;
    assign rd_data = rctl_q.data;
    assign rd_err  = rctl_q.err;

endmodule

// File: rtl/edge_offset_fifo.sv
module edge_offset_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int AE_OFS = 3,
    parameter int AF_OFS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty,
    output logic              almost_full,
    output logic              wr_err,
    output logic              rd_err
);

    localparam int PW  = efifo_pkg::ptr_width(DEPTH);
    localparam int AW  = $clog2(DEPTH);
    localparam logic [PW-1:0] DEPTH_L = PW'(DEPTH);
    localparam logic [PW-1:0] AE_L    = PW'(AE_OFS);
    localparam logic [PW-1:0] AF_L    = PW'(AF_OFS);

    logic              stg_vld;
    logic [DATA_W-1:0] stg_data;
    logic              mem_we;
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PW-1:0]     count;
    logic [PW-1:0]     space;
    efifo_pkg::efifo_err_t errs;

    efifo_wr_stage #(.DATA_W(DATA_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .stg_vld  (stg_vld),
        .stg_data (stg_data)
    );

    efifo_wr_ctrl #(.DEPTH(DEPTH)) u_wctl (
        .clk     (clk),
        .rst     (rst),
        .stg_vld (stg_vld),
        .rd_ptr  (rd_ptr),
        .mem_we  (mem_we),
        .wr_ptr  (wr_ptr),
        .wr_err  (errs.wr_err)
    );

    efifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (stg_data),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (mem_rdata)
    );

    efifo_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rctl (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .is_empty  (empty),
        .mem_rdata (mem_rdata),
        .rd_ptr    (rd_ptr),
        .rd_data   (rd_data),
        .rd_err    (errs.rd_err)
    );

    // Flags decode straight from the pointers: no register on the read path.
    always_comb begin
        count        = wr_ptr - rd_ptr;
        space        = DEPTH_L - count;
        almost_empty = (count <= AE_L);
        empty        = almost_empty && (count == '0);
        almost_full  = (space <= AF_L);
    end

    assign wr_err = errs.wr_err;
    assign rd_err = errs.rd_err;

endmodule

// File: rtl/efifo_chk.sv
module efifo_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              empty,
    input logic              almost_empty,
    input logic              almost_full,
    input logic              wr_err,
    input logic              rd_err
);

    assert_empty_in_ae_R4: assert property (@(posedge clk) disable iff (rst)
        empty |-> almost_empty);

    assert_rd_err_on_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> rd_err);

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> $stable(rd_data));

    assert_werr_af_R6: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> almost_full);

    assert_rd_ok_no_err_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty) |=> !rd_err);

endmodule

bind edge_offset_fifo efifo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .empty        (empty),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .wr_err       (wr_err),
    .rd_err       (rd_err)
);

// File: tb/tb_edge_offset_fifo.sv
module tb_edge_offset_fifo;

    localparam int PERIOD = 10;
    localparam int DW     = 8;
    localparam int DEP    = 8;
    localparam int AE     = 2;
    localparam int AF     = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          empty, almost_empty, almost_full, wr_err, rd_err;

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] model_q[$];
    logic [DW-1:0] last_rd = '0;
    bit            mdl_werr = 1'b0;
    bit            mdl_rerr = 1'b0;

    edge_offset_fifo #(.DATA_W(DW), .DEPTH(DEP), .AE_OFS(AE), .AF_OFS(AF)) dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .empty        (empty),
        .almost_empty (almost_empty),
        .almost_full  (almost_full),
        .wr_err       (wr_err),
        .rd_err       (rd_err)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, let a rising and a falling
    // edge pass, sample just after the falling edge.
    task automatic cyc(input bit we, input logic [DW-1:0] wd, input bit re);
        int cnt;
        wr_en   = we;
        wr_data = wd;
        rd_en   = re;
        @(negedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        // R9 ordering: read judged first, write after it
        mdl_rerr = re && (model_q.size() == 0);
        if (re && !mdl_rerr) last_rd = model_q.pop_front();
        mdl_werr = we && (model_q.size() == DEP);
        if (we && !mdl_werr) model_q.push_back(wd);
        cnt = model_q.size();
        chk("R3 rd_data", int'(rd_data), int'(last_rd));
        chk("R4 almost_empty", int'(almost_empty), int'(cnt <= AE));
        chk("R4 empty", int'(empty), int'(cnt == 0));
        chk("R5 almost_full", int'(almost_full), int'(DEP - cnt <= AF));
        chk("R6 wr_err", int'(wr_err), int'(mdl_werr));
        chk("R7 rd_err", int'(rd_err), int'(mdl_rerr));
    endtask

    task automatic drain();
        while (model_q.size() > 0) cyc(1'b0, '0, 1'b1);
    endtask

    task automatic t_reset_r1();
        chk("R1 empty", int'(empty), 1);
        chk("R1 almost_empty", int'(almost_empty), 1);
        chk("R1 almost_full", int'(almost_full), 0);
        chk("R1 wr_err", int'(wr_err), 0);
        chk("R1 rd_err", int'(rd_err), 0);
        chk("R1 rd_data", int'(rd_data), 0);
    endtask

    task automatic t_order_r2();
        cyc(1'b1, 8'h11, 1'b0);
        chk("R2 write visible after one cycle", int'(empty), 0);
        for (int i = 0; i < 4; i++) cyc(1'b1, 8'h20 + 8'(i), 1'b0);
        cyc(1'b0, '0, 1'b1);
        chk("R2 oldest first", int'(rd_data), 'h11);
        cyc(1'b1, 8'h5A, 1'b1);
        chk("R3 second word", int'(rd_data), 'h20);
        drain();
        chk("R2 last word order", int'(rd_data), 'h5A);
    endtask

    task automatic t_ae_threshold_r8();
        cyc(1'b1, 8'h31, 1'b0);
        cyc(1'b1, 8'h32, 1'b0);
        cyc(1'b1, 8'h33, 1'b1);
        chk("R8 from below ae held", int'(almost_empty), 1);
        cyc(1'b1, 8'h34, 1'b1);
        chk("R8 count kept ae", int'(almost_empty), 1);
        cyc(1'b1, 8'h35, 1'b0);
        chk("R8 above threshold", int'(almost_empty), 0);
        cyc(1'b0, '0, 1'b1);
        cyc(1'b1, 8'h36, 1'b1);
        chk("R8 from above ae held", int'(almost_empty), 1);
        drain();
    endtask

    task automatic t_full_r6();
        for (int i = 0; i < DEP; i++) cyc(1'b1, 8'h40 + 8'(i), 1'b0);
        chk("R5 full implies almost_full", int'(almost_full), 1);
        cyc(1'b1, 8'hEE, 1'b0);
        chk("R6 overflow flagged", int'(wr_err), 1);
        cyc(1'b0, '0, 1'b0);
        chk("R6 err is a pulse", int'(wr_err), 0);
        // R9: simultaneous read and write on a full buffer
        cyc(1'b1, 8'h48, 1'b1);
        chk("R9 full rw no wr_err", int'(wr_err), 0);
        chk("R6 contents intact", int'(rd_data), 'h40);
        drain();
        chk("R6 tail word", int'(rd_data), 'h48);
    endtask

    task automatic t_empty_r7();
        logic [DW-1:0] held;
        held = rd_data;
        cyc(1'b0, '0, 1'b1);
        chk("R7 underflow flagged", int'(rd_err), 1);
        chk("R7 rd_data held", int'(rd_data), int'(held));
        // R9: simultaneous read and write on an empty buffer
        cyc(1'b1, 8'h77, 1'b1);
        chk("R9 empty rw read refused", int'(rd_err), 1);
        chk("R9 empty rw write taken", int'(empty), 0);
        cyc(1'b0, '0, 1'b1);
        chk("R9 word readable", int'(rd_data), 'h77);
    endtask

    task automatic t_throttle_r10();
        int guard = 0;
        bit saw_err = 1'b0;
        while (!almost_full && guard < 4 * DEP) begin
            cyc(1'b1, 8'h90 + 8'(guard), 1'b0);
            if (wr_err) saw_err = 1'b1;
            guard++;
        end
        chk("R10 no overflow", int'(saw_err), 0);
        chk("R10 settled count", model_q.size(), DEP - AF);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset_r1();
        rst = 1'b0;
        @(negedge clk);
        #1;
        t_reset_r1();
        t_order_r2();
        t_ae_threshold_r8();
        t_full_r6();
        t_empty_r7();
        t_throttle_r10();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule